// File: doc/BRIEF.md
# Double-Banked OUT Endpoint Receive Buffer

This block stores the data of one bulk or interrupt OUT endpoint in two packet banks that fill by turns. The link side presents each OUT transaction as a start strobe, a run of byte strobes and an end strobe with a good/bad status. The buffer answers every accepted transaction with a one-cycle ACK pulse, or with a NAK pulse when no bank is free. Token decoding, CRC, data toggles and the serial engine sit outside the block.

Firmware watches one received flag per bank and the byte count of the bank selected for reading. It pulls bytes one at a time through a read strobe, then clears that bank's flag. Clearing the flag hands the bank back to the link side and moves the read side to the other bank. An interrupt line follows the flags when it is enabled.

Each bank is `BANK_BYTES` deep, a power of two. A byte strobe never falls in the same cycle as the end strobe.

Top module: `pp_out_endpoint`

## Requirements
- R1: While `ep_enable` and `ep_config` are not both high, a transaction produces no ACK, no NAK and no change of flags.
- R2: A packet ending with `lk_good` high and no more than `BANK_BYTES` bytes sets the target bank's flag in the edge that samples `lk_end`. `lk_ack` pulses high for exactly the cycle after that edge.
- R3: Accepted packets go to bank 0 first, then alternate between bank 1 and bank 0. Bit b of `fw_rx_flag` is the flag of bank b.
- R4: `irq` is high one cycle after any flag is set while `irq_en` is high. It is low whenever `irq_en` was low in the previous cycle.
- R5: A packet of zero bytes sets its flag, answers ACK, and reports a `fw_count` of 0.
- R6: `fw_count` gives the stored byte count of the bank named by `fw_rd_bank`. Pulsing bit b of `fw_clr` while flag b is set clears that flag, zeroes that bank's count and read pointer, and sets `fw_rd_bank` to the other bank.
- R7: If both flags are set when `lk_start` is sampled, `lk_nak` pulses in the next cycle and nothing is written. A bank whose flag is set is never written.
- R8: A packet that ends with `lk_good` low, or that carries more than `BANK_BYTES` bytes, sets no flag and sends no handshake. The next accepted packet goes to the same bank.
- R9: Each `fw_rd_strobe` returns the next stored byte of the read bank on `fw_rd_data`, starting from byte 0. The byte appears in the cycle after the strobe.
- R10: A read strobe beyond the stored count, or on a bank with no flag, returns 0. It also sets `fw_underrun`, which stays high until reset.
- R11: A `fw_clr` bit for a bank whose flag is clear changes nothing.
- R12: After a synchronous reset, flags, `irq`, `fw_count`, `fw_rd_bank` and `fw_underrun` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| ep_enable | input | 1 | Endpoint enabled |
| ep_config | input | 1 | Endpoint configured |
| irq_en | input | 1 | Interrupt enable |
| lk_start | input | 1 | OUT transaction begins |
| lk_byte_vld | input | 1 | Data byte valid |
| lk_byte | input | DATA_W | Data byte |
| lk_end | input | 1 | Packet end strobe |
| lk_good | input | 1 | Packet status at end (1 = good) |
| lk_ack | output | 1 | ACK handshake pulse |
| lk_nak | output | 1 | NAK handshake pulse |
| fw_rx_flag | output | 2 | Per-bank received flags |
| fw_rd_bank | output | 1 | Bank selected for firmware reads |
| fw_count | output | $clog2(BANK_BYTES+1) | Byte count of the read bank |
| fw_rd_strobe | input | 1 | Firmware read strobe |
| fw_rd_data | output | DATA_W | Read data |
| fw_clr | input | 2 | Per-bank flag clear strobes |
| fw_underrun | output | 1 | Sticky read-past-end flag |
| irq | output | 1 | Interrupt request |

## Verification
The bench sweeps every packet length from zero through two bytes past the bank size on a small bank, and reads each stored packet back byte by byte. A design that miscounted at the full-bank edge would either reject a full packet or accept an overflowing one. A design that treated a zero-length packet as nothing would leave the flag clear. The bench fills both banks and checks that the next packet is refused with NAK and that the count of the first bank is unchanged. It also checks that a bad or oversize packet does not consume a bank turn, so the next accepted packet still lands in the expected bank. Clear strobes for an empty bank, reads past the end, and the enable/configure gate are checked at the ports, where a faulty design would move the read bank, return stale bytes or answer while disabled.

// File: rtl/pp_out_pkg.sv
package pp_out_pkg;
  typedef enum logic {
    LK_IDLE = 1'b0,
    LK_RECV = 1'b1
  } lk_state_t;
endpackage

// File: rtl/pp_bank_store.sv
module pp_bank_store #(
  parameter int DATA_W     = 8,
  parameter int BANK_BYTES = 64,
  localparam int IDX_W     = $clog2(BANK_BYTES),
  localparam int DEPTH     = 2 * BANK_BYTES
) (
  input  logic              clk,
  input  logic              wr_en,
  input  logic              wr_bank,
  input  logic [IDX_W-1:0]  wr_idx,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              rd_en,
  input  logic              rd_bank,
  input  logic [IDX_W-1:0]  rd_idx,
  output logic [DATA_W-1:0] rd_q
);
  logic [DATA_W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (wr_en) mem[{wr_bank, wr_idx}] <= wr_data;
  end

  always_ff @(posedge clk) begin
    if (rd_en) rd_q <= mem[{rd_bank, rd_idx}];
  end
endmodule

// File: rtl/pp_link_ctrl.sv
module pp_link_ctrl
  import pp_out_pkg::*;
#(
  parameter int DATA_W     = 8,
  parameter int BANK_BYTES = 64,
  localparam int IDX_W     = $clog2(BANK_BYTES),
  localparam int CNT_W     = $clog2(BANK_BYTES + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              active_i,
  input  logic [1:0]        flag_i,
  input  logic              start_i,
  input  logic              byte_vld_i,
  input  logic [DATA_W-1:0] byte_i,
  input  logic              end_i,
  input  logic              good_i,
  output logic              ack_o,
  output logic              nak_o,
  output logic              wr_en_o,
  output logic              wr_bank_o,
  output logic [IDX_W-1:0]  wr_idx_o,
  output logic [DATA_W-1:0] wr_data_o,
  output logic              commit_o,
  output logic              commit_bank_o,
  output logic [CNT_W-1:0]  commit_len_o
);
  localparam logic [CNT_W-1:0] FULL = CNT_W'(BANK_BYTES);

  lk_state_t        state;
  logic             tgt;
  logic             wr_ptr;
  logic [CNT_W-1:0] wcnt;
  logic             ovf;
  logic             in_pkt;
  logic             pick;

  assign in_pkt = active_i && (state == LK_RECV);
  assign pick   = flag_i[wr_ptr] ? ~wr_ptr : wr_ptr;

  assign wr_en_o       = in_pkt && byte_vld_i && !end_i && (wcnt != FULL);
  assign wr_bank_o     = tgt;
  assign wr_idx_o      = wcnt[IDX_W-1:0];
  assign wr_data_o     = byte_i;
  assign commit_o      = in_pkt && end_i && good_i && !ovf;
  assign commit_bank_o = tgt;
  assign commit_len_o  = wcnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      state  <= LK_IDLE;
      tgt    <= 1'b0;
      wr_ptr <= 1'b0;
      wcnt   <= '0;
      ovf    <= 1'b0;
      ack_o  <= 1'b0;
      nak_o  <= 1'b0;
    end else begin
      ack_o <= 1'b0;
      nak_o <= 1'b0;
      if (!active_i) begin
        state <= LK_IDLE;
      end else begin
        unique case (state)
          LK_IDLE: begin
            if (start_i) begin
              if (&flag_i) begin
                nak_o <= 1'b1;
              end else begin
                state <= LK_RECV;
                tgt   <= pick;
                wcnt  <= '0;
                ovf   <= 1'b0;
              end
            end
          end
          LK_RECV: begin
            if (end_i) begin
              state <= LK_IDLE;
              if (good_i && !ovf) begin
                ack_o  <= 1'b1;
                wr_ptr <= ~tgt;
              end
            end else if (byte_vld_i) begin
              if (wcnt == FULL) ovf  <= 1'b1;
              else              wcnt <= wcnt + 1'b1;
            end
          end
          default: state <= LK_IDLE;
        endcase
      end
    end
  end

  // R7: a NAK follows only a start seen with both banks held
  a_r7_nak_when_full: assert property (@(posedge clk) disable iff (rst)
    nak_o |-> $past(flag_i) == 2'b11);
  // R7: no byte is written into a bank that firmware still holds
  a_r7_no_overwrite: assert property (@(posedge clk) disable iff (rst)
    wr_en_o |-> !flag_i[wr_bank_o]);
  // R1: handshakes only while enabled and configured
  a_r1_ack_gated: assert property (@(posedge clk) disable iff (rst)
    (ack_o || nak_o) |-> $past(active_i));
  // R2: ACK and NAK never together
  a_r2_one_handshake: assert property (@(posedge clk) disable iff (rst)
    !(ack_o && nak_o));
  // R8: a discarded end produces no ACK
  a_r8_discard_silent: assert property (@(posedge clk) disable iff (rst)
    (in_pkt && end_i && !commit_o) |=> !ack_o);
endmodule

// File: rtl/pp_fw_port.sv
module pp_fw_port #(
  parameter int BANK_BYTES = 64,
  localparam int IDX_W     = $clog2(BANK_BYTES),
  localparam int CNT_W     = $clog2(BANK_BYTES + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             irq_en_i,
  input  logic             commit_i,
  input  logic             commit_bank_i,
  input  logic [CNT_W-1:0] commit_len_i,
  input  logic             rd_strobe_i,
  input  logic [1:0]       clr_i,
  output logic [1:0]       flag_o,
  output logic             rd_bank_o,
  output logic [CNT_W-1:0] count_o,
  output logic             mem_rd_en_o,
  output logic [IDX_W-1:0] mem_rd_idx_o,
  output logic             zero_o,
  output logic             underrun_o,
  output logic             irq_o
);
  logic [CNT_W-1:0] cnt  [2];
  logic [CNT_W-1:0] rptr [2];
  logic [1:0]       rel;
  logic             rd_ok;

  assign rd_ok        = flag_o[rd_bank_o] && (rptr[rd_bank_o] < cnt[rd_bank_o]);
  assign mem_rd_en_o  = rd_strobe_i && rd_ok;
  assign mem_rd_idx_o = rptr[rd_bank_o][IDX_W-1:0];
  assign count_o      = cnt[rd_bank_o];

  for (genvar g = 0; g < 2; g++) begin : g_bank
    assign rel[g] = clr_i[g] && flag_o[g];

    always_ff @(posedge clk) begin
      if (rst) begin
        flag_o[g] <= 1'b0;
        cnt[g]    <= '0;
        rptr[g]   <= '0;
      end else begin
        if (mem_rd_en_o && (rd_bank_o == 1'(g))) rptr[g] <= rptr[g] + 1'b1;
        if (commit_i && (commit_bank_i == 1'(g))) begin
          flag_o[g] <= 1'b1;
          cnt[g]    <= commit_len_i;
          rptr[g]   <= '0;
        end else if (rel[g]) begin
          flag_o[g] <= 1'b0;
          cnt[g]    <= '0;
          rptr[g]   <= '0;
        end
      end
    end

    // R11: a clear aimed at an empty bank leaves it empty
    a_r11_clr_ignored: assert property (@(posedge clk) disable iff (rst)
      (clr_i[g] && !flag_o[g] && !(commit_i && commit_bank_i == 1'(g)))
        |=> !flag_o[g]);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_bank_o  <= 1'b0;
      zero_o     <= 1'b0;
      underrun_o <= 1'b0;
      irq_o      <= 1'b0;
    end else begin
      if (rel[0]) rd_bank_o <= 1'b1;
      if (rel[1]) rd_bank_o <= 1'b0;
      if (rd_strobe_i) zero_o <= !rd_ok;
      if (rd_strobe_i && !rd_ok) underrun_o <= 1'b1;
      irq_o <= irq_en_i && (|flag_o);
    end
  end

  // R4: the interrupt follows the flags only while enabled
  a_r4_irq_gated: assert property (@(posedge clk) disable iff (rst)
    irq_o |-> $past(irq_en_i));
  a_r4_irq_raise: assert property (@(posedge clk) disable iff (rst)
    (irq_en_i && (|flag_o)) |=> irq_o);
  // R10: underrun stays set
  a_r10_underrun_sticky: assert property (@(posedge clk) disable iff (rst)
    underrun_o |=> underrun_o);
  // R6: a released bank reports a zero count
  a_r6_free_count_zero: assert property (@(posedge clk) disable iff (rst)
    !flag_o[rd_bank_o] |-> (count_o == '0));
  // R6: releasing a bank moves the read side away from it
  a_r6_read_moves: assert property (@(posedge clk) disable iff (rst)
    (rel == 2'b01) |=> rd_bank_o);
endmodule

// File: rtl/pp_out_endpoint.sv
module pp_out_endpoint #(
  parameter int DATA_W     = 8,
  parameter int BANK_BYTES = 64,
  localparam int IDX_W     = $clog2(BANK_BYTES),
  localparam int CNT_W     = $clog2(BANK_BYTES + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ep_enable,
  input  logic              ep_config,
  input  logic              irq_en,
  input  logic              lk_start,
  input  logic              lk_byte_vld,
  input  logic [DATA_W-1:0] lk_byte,
  input  logic              lk_end,
  input  logic              lk_good,
  output logic              lk_ack,
  output logic              lk_nak,
  output logic [1:0]        fw_rx_flag,
  output logic              fw_rd_bank,
  output logic [CNT_W-1:0]  fw_count,
  input  logic              fw_rd_strobe,
  output logic [DATA_W-1:0] fw_rd_data,
  input  logic [1:0]        fw_clr,
  output logic              fw_underrun,
  output logic              irq
);
  logic              active;
  logic              wr_en;
  logic              wr_bank;
  logic [IDX_W-1:0]  wr_idx;
  logic [DATA_W-1:0] wr_data;
  logic              commit;
  logic              commit_bank;
  logic [CNT_W-1:0]  commit_len;
  logic              mem_rd_en;
  logic [IDX_W-1:0]  mem_rd_idx;
  logic [DATA_W-1:0] mem_q;
  logic              zero_sel;

  assign active     = ep_enable && ep_config;
  assign fw_rd_data = zero_sel ? '0 : mem_q;

  pp_link_ctrl #(.DATA_W(DATA_W), .BANK_BYTES(BANK_BYTES)) u_link (
    .clk(clk), .rst(rst), .active_i(active), .flag_i(fw_rx_flag),
    .start_i(lk_start), .byte_vld_i(lk_byte_vld), .byte_i(lk_byte),
    .end_i(lk_end), .good_i(lk_good), .ack_o(lk_ack), .nak_o(lk_nak),
    .wr_en_o(wr_en), .wr_bank_o(wr_bank), .wr_idx_o(wr_idx),
    .wr_data_o(wr_data), .commit_o(commit), .commit_bank_o(commit_bank),
    .commit_len_o(commit_len)
  );

  pp_bank_store #(.DATA_W(DATA_W), .BANK_BYTES(BANK_BYTES)) u_store (
    .clk(clk), .wr_en(wr_en), .wr_bank(wr_bank), .wr_idx(wr_idx),
    .wr_data(wr_data), .rd_en(mem_rd_en), .rd_bank(fw_rd_bank),
    .rd_idx(mem_rd_idx), .rd_q(mem_q)
  );

  pp_fw_port #(.BANK_BYTES(BANK_BYTES)) u_fw (
    .clk(clk), .rst(rst), .irq_en_i(irq_en), .commit_i(commit),
    .commit_bank_i(commit_bank), .commit_len_i(commit_len),
    .rd_strobe_i(fw_rd_strobe), .clr_i(fw_clr), .flag_o(fw_rx_flag),
    .rd_bank_o(fw_rd_bank), .count_o(fw_count), .mem_rd_en_o(mem_rd_en),
    .mem_rd_idx_o(mem_rd_idx), .zero_o(zero_sel), .underrun_o(fw_underrun),
    .irq_o(irq)
  );

  // R1: flags only rise while the endpoint is active
  a_r1_no_flag_inactive: assert property (@(posedge clk) disable iff (rst)
    ((fw_rx_flag & ~$past(fw_rx_flag)) != 2'b00) |-> $past(active));
  // R2: a newly raised flag comes with an ACK
  a_r2_flag_with_ack: assert property (@(posedge clk) disable iff (rst)
    ((fw_rx_flag & ~$past(fw_rx_flag)) != 2'b00) |-> lk_ack);
  // R3: no two flags rise in the same cycle
  a_r3_single_rise: assert property (@(posedge clk) disable iff (rst)
    $countones(fw_rx_flag & ~$past(fw_rx_flag)) <= 1);
endmodule

// File: tb/test_pp_out_endpoint.sv
module test_pp_out_endpoint;
  localparam int CLK_PERIOD = 10;
  localparam int BB = 8;
  localparam int CW = $clog2(BB + 1);

  logic clk = 1'b0;
  logic rst, ep_enable, ep_config, irq_en;
  logic lk_start, lk_byte_vld, lk_end, lk_good;
  logic [7:0] lk_byte;
  logic lk_ack, lk_nak;
  logic [1:0] fw_rx_flag;
  logic fw_rd_bank;
  logic [CW-1:0] fw_count;
  logic fw_rd_strobe;
  logic [7:0] fw_rd_data;
  logic [1:0] fw_clr;
  logic fw_underrun, irq;

  int checks = 0;
  int errors = 0;
  logic got_ack, got_nak, stray;
  logic exp_bank;

  always #(CLK_PERIOD/2) clk = ~clk;

  pp_out_endpoint #(.DATA_W(8), .BANK_BYTES(BB)) i_pp_out_endpoint (
    .clk(clk), .rst(rst), .ep_enable(ep_enable), .ep_config(ep_config),
    .irq_en(irq_en), .lk_start(lk_start), .lk_byte_vld(lk_byte_vld),
    .lk_byte(lk_byte), .lk_end(lk_end), .lk_good(lk_good), .lk_ack(lk_ack),
    .lk_nak(lk_nak), .fw_rx_flag(fw_rx_flag), .fw_rd_bank(fw_rd_bank),
    .fw_count(fw_count), .fw_rd_strobe(fw_rd_strobe), .fw_rd_data(fw_rd_data),
    .fw_clr(fw_clr), .fw_underrun(fw_underrun), .irq(irq)
  );

  function automatic logic [7:0] pat(int n, int i);
    return 8'((n * 16 + i * 3 + 1) & 255);
  endfunction

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic send(int n, logic good);
    got_ack = 1'b0; got_nak = 1'b0; stray = 1'b0;
    @(negedge clk) lk_start = 1'b1;
    @(negedge clk) lk_start = 1'b0;
    got_nak = lk_nak;
    for (int i = 0; i < n; i++) begin
      lk_byte_vld = 1'b1; lk_byte = pat(n, i);
      @(negedge clk);
      if (lk_ack || lk_nak) stray = 1'b1;
    end
    lk_byte_vld = 1'b0;
    lk_end = 1'b1; lk_good = good;
    @(negedge clk) lk_end = 1'b0; lk_good = 1'b0;
    got_ack = lk_ack;
  endtask

  task automatic rd(output logic [7:0] d);
    @(negedge clk) fw_rd_strobe = 1'b1;
    @(negedge clk) fw_rd_strobe = 1'b0;
    d = fw_rd_data;
  endtask

  task automatic clr(logic [1:0] m);
    @(negedge clk) fw_clr = m;
    @(negedge clk) fw_clr = 2'b00;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [7:0] d;
    rst = 1'b1; ep_enable = 1'b0; ep_config = 1'b0; irq_en = 1'b0;
    lk_start = 1'b0; lk_byte_vld = 1'b0; lk_end = 1'b0; lk_good = 1'b0;
    lk_byte = '0; fw_rd_strobe = 1'b0; fw_clr = 2'b00;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R12 reset state
    chk("R12 flags", int'(fw_rx_flag), 0);
    chk("R12 irq", int'(irq), 0);
    chk("R12 count", int'(fw_count), 0);
    chk("R12 rd_bank", int'(fw_rd_bank), 0);
    chk("R12 underrun", int'(fw_underrun), 0);

    // R1: enabled but not configured, then configured but not enabled
    ep_enable = 1'b1;
    send(3, 1'b1);
    chk("R1 ack gated", int'(got_ack | got_nak), 0);
    chk("R1 flags gated", int'(fw_rx_flag), 0);
    ep_enable = 1'b0; ep_config = 1'b1;
    send(2, 1'b1);
    chk("R1 ack gated 2", int'(got_ack | got_nak), 0);
    chk("R1 flags gated 2", int'(fw_rx_flag), 0);
    ep_enable = 1'b1;

    // R2/R3: first packet into bank 0, irq stays low while disabled
    send(3, 1'b1);
    chk("R2 ack", int'(got_ack), 1);
    chk("R2 no early handshake", int'(stray), 0);
    chk("R3 bank0 first", int'(fw_rx_flag), 1);
    chk("R2 count", int'(fw_count), 3);
    @(negedge clk);
    chk("R4 irq disabled", int'(irq), 0);
    irq_en = 1'b1;
    @(negedge clk);
    chk("R4 irq raised", int'(irq), 1);

    // R3 then R7: second to bank 1, third refused
    send(5, 1'b1);
    chk("R3 bank1 second", int'(fw_rx_flag), 3);
    send(4, 1'b1);
    chk("R7 nak", int'(got_nak), 1);
    chk("R7 no ack", int'(got_ack), 0);
    chk("R7 count kept", int'(fw_count), 3);

    // R9/R10 read bank 0 and beyond
    for (int i = 0; i < 3; i++) begin
      rd(d);
      chk("R9 data bank0", int'(d), int'(pat(3, i)));
    end
    chk("R10 no underrun yet", int'(fw_underrun), 0);
    rd(d);
    chk("R10 zero past end", int'(d), 0);
    chk("R10 underrun set", int'(fw_underrun), 1);

    // R6 release bank 0
    clr(2'b01);
    chk("R6 flags", int'(fw_rx_flag), 2);
    chk("R6 rd_bank", int'(fw_rd_bank), 1);
    chk("R6 count other", int'(fw_count), 5);
    for (int i = 0; i < 5; i++) begin
      rd(d);
      chk("R9 data bank1", int'(d), int'(pat(5, i)));
    end
    // R11 clear of empty bank 0 ignored
    clr(2'b01);
    chk("R11 flags", int'(fw_rx_flag), 2);
    chk("R11 rd_bank", int'(fw_rd_bank), 1);
    chk("R11 count", int'(fw_count), 5);
    chk("R10 sticky", int'(fw_underrun), 1);
    clr(2'b10);
    chk("R6 all free", int'(fw_rx_flag), 0);
    chk("R6 back to 0", int'(fw_rd_bank), 0);
    chk("R6 count zero", int'(fw_count), 0);
    @(negedge clk);
    chk("R4 irq low", int'(irq), 0);

    // R8 bad status and oversize, then next good goes to bank 0
    send(2, 1'b0);
    chk("R8 bad no ack", int'(got_ack | got_nak), 0);
    chk("R8 bad no flag", int'(fw_rx_flag), 0);
    send(BB + 1, 1'b1);
    chk("R8 oversize no ack", int'(got_ack | got_nak), 0);
    chk("R8 oversize no flag", int'(fw_rx_flag), 0);

    // R5 zero-length packet
    send(0, 1'b1);
    chk("R5 zlp ack", int'(got_ack), 1);
    chk("R5 zlp flag bank0", int'(fw_rx_flag), 1);
    chk("R5 zlp count", int'(fw_count), 0);
    clr(2'b01);
    exp_bank = 1'b1;

    // Sweep lengths 0 .. BB+2 with alternation tracking
    for (int n = 0; n <= BB + 2; n++) begin
      send(n, 1'b1);
      if (n <= BB) begin
        chk("R2 sweep ack", int'(got_ack), 1);
        chk("R3 sweep bank", int'(fw_rx_flag), exp_bank ? 2 : 1);
        chk("R6 sweep rd_bank", int'(fw_rd_bank), int'(exp_bank));
        chk("R2 sweep count", int'(fw_count), n);
        for (int i = 0; i < n; i++) begin
          rd(d);
          chk("R9 sweep data", int'(d), int'(pat(n, i)));
        end
        clr(exp_bank ? 2'b10 : 2'b01);
        chk("R6 sweep release", int'(fw_rx_flag), 0);
        exp_bank = ~exp_bank;
      end else begin
        chk("R8 sweep reject", int'(got_ack | got_nak), 0);
        chk("R8 sweep no flag", int'(fw_rx_flag), 0);
      end
    end

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule